// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block turns pointer-based memory accesses into data-memory addresses. It holds nine 16-bit pointers: eight auxiliary pointers and one coefficient pointer. Each pointer is in either linear or circular mode. A linear pointer is itself the address, and after the access it moves by a signed step with plain 16-bit wraparound. A circular pointer is an offset inside a buffer. Its address is the buffer's start plus that offset, and after the access the offset moves by the step and wraps back into the buffer.

Buffer geometry is shared. One size register serves auxiliary pointers 0 to 3 and a second serves pointers 4 to 7. Four start registers each serve one adjacent pair of auxiliary pointers. The coefficient pointer has its own size and start. Software-side setup goes through one write port: a kind code, an index and a data word. Accesses come in as a request that carries a pointer index and a signed step. The address and the new pointer value come back one cycle later with a valid flag, and the new value is stored for the next access.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, `vld_o` is low and every pointer, size, start and mode bit is zero, so every pointer is linear at offset 0.
- R2: For a linear pointer, one cycle after a request `vld_o` is high, `addr_o` equals the pointer before update and `ptr_o` equals pointer plus step modulo 2^16.
- R3: For a circular pointer, `addr_o` is the pre-update offset plus the selected start address, modulo 2^16. Auxiliary pointer n uses start index n/2 and the coefficient pointer uses start index 4.
- R4: In circular mode with size greater than 1, an offset+step result at or above the size has the size subtracted from it.
- R5: In circular mode with size greater than 1, an offset+step result below zero has the size added to it.
- R6: Size index 0 governs pointers 0..3, size index 1 governs pointers 4..7, and size index 2 governs the coefficient pointer (pointer index 8).
- R7: A circular pointer whose size is 0 or 1 keeps its value, and an address is still produced.
- R8: When a pointer write and an update of the same pointer fall in one cycle, the written value is stored. `ptr_o` still shows the computed update.
- R9: With no request, or with a pointer index above 8, `vld_o` is low in the following cycle and no pointer changes.
- R10: Write kind codes are 0 = pointer (index 0..8), 1 = size (index 0..2), 2 = start (index 0..4) and 3 = mode. For a mode write, data bit 0 set to 1 selects circular.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Write target kind (R10) |
| wr_idx_i | input | 4 | Write target index |
| wr_data_i | input | 16 | Write data |
| req_i | input | 1 | Access request |
| req_ptr_i | input | 4 | Pointer index, 0..7 auxiliary, 8 coefficient |
| req_step_i | input | 16 | Signed post-access step |
| vld_o | output | 1 | Result valid |
| addr_o | output | 16 | Effective address |
| ptr_o | output | 16 | Updated pointer value |

## Verification
A corrupted pointer register shows in `addr_o` on the very next access to that pointer, one cycle after the request. A wrong shared size or start only shows when a pointer of the affected group or pair is accessed. The tests therefore touch every group, both pairs in use and the coefficient pointer. Wrap faults can stay hidden until an offset reaches an exact boundary. The tests hit offset+step equal to the size, a step equal to the full size in both directions, and a result of exactly -1.

// File: rtl/cag_pkg.sv
package cag_pkg;
  typedef enum logic [1:0] {
    WR_PTR   = 2'd0,
    WR_SIZE  = 2'd1,
    WR_START = 2'd2,
    WR_MODE  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/cag_regfile.sv
module cag_regfile
  import cag_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NUM_AR = 8,
  localparam int NUM_PTR   = NUM_AR + 1,
  localparam int PIW       = $clog2(NUM_PTR),
  localparam int NUM_START = NUM_AR / 2 + 1,
  localparam int NUM_SIZE  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  wr_kind_e      wr_kind_i,
  input  logic [PIW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [PIW-1:0] upd_idx_i,
  input  logic [AW-1:0] upd_val_i,
  output logic [AW-1:0] ptr_o   [NUM_PTR],
  output logic          mode_o  [NUM_PTR],
  output logic [AW-1:0] size_o  [NUM_SIZE],
  output logic [AW-1:0] start_o [NUM_START]
);

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_kind_i == WR_PTR) && (wr_idx_i == PIW'(g));

    // register write wins over the access update
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ptr_o[g] <= '0;
      else if (wr_hit)                           ptr_o[g] <= wr_data_i;
      else if (upd_en_i && upd_idx_i == PIW'(g)) ptr_o[g] <= upd_val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_o[g] <= 1'b0;
      else if (wr_en_i && wr_kind_i == WR_MODE && wr_idx_i == PIW'(g))
        mode_o[g] <= wr_data_i[0];
    end
  end

  for (genvar s = 0; s < NUM_SIZE; s++) begin : g_size
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) size_o[s] <= '0;
      else if (wr_en_i && wr_kind_i == WR_SIZE && wr_idx_i == PIW'(s))
        size_o[s] <= wr_data_i;
    end
  end

  for (genvar b = 0; b < NUM_START; b++) begin : g_start
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_o[b] <= '0;
      else if (wr_en_i && wr_kind_i == WR_START && wr_idx_i == PIW'(b))
        start_o[b] <= wr_data_i;
    end
  end

endmodule

// File: rtl/cag_select.sv
module cag_select #(
  parameter int AW     = 16,
  parameter int NUM_AR = 8,
  localparam int NUM_PTR   = NUM_AR + 1,
  localparam int PIW       = $clog2(NUM_PTR),
  localparam int NUM_START = NUM_AR / 2 + 1,
  localparam int NUM_SIZE  = 3
) (
  input  logic [PIW-1:0] idx_i,
  input  logic [AW-1:0]  ptr_i   [NUM_PTR],
  input  logic           mode_i  [NUM_PTR],
  input  logic [AW-1:0]  size_i  [NUM_SIZE],
  input  logic [AW-1:0]  start_i [NUM_START],
  output logic [AW-1:0]  cur_o,
  output logic           circ_o,
  output logic [AW-1:0]  size_o,
  output logic [AW-1:0]  start_o
);

  logic [PIW-1:0] pair_idx;
  logic           is_coef;
  logic           hi_group;

  assign is_coef  = (idx_i == PIW'(NUM_AR));
  assign hi_group = (idx_i >= PIW'(NUM_AR / 2));
  assign pair_idx = is_coef ? PIW'(NUM_START - 1) : (idx_i >> 1);

  always_comb begin
    cur_o  = '0;
    circ_o = 1'b0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (idx_i == PIW'(i)) begin
        cur_o  = ptr_i[i];
        circ_o = mode_i[i];
      end
    end
  end

  always_comb begin
    start_o = '0;
    for (int j = 0; j < NUM_START; j++)
      if (pair_idx == PIW'(j)) start_o = start_i[j];
  end

  always_comb begin
    if (is_coef)       size_o = size_i[2];
    else if (hi_group) size_o = size_i[1];
    else               size_o = size_i[0];
  end

endmodule

// File: rtl/cag_step.sv
module cag_step #(
  parameter int AW = 16,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] size_i,
  input  logic          circ_i,
  output logic [AW-1:0] nxt_o
);

  logic signed [EW-1:0] sum;
  logic signed [EW-1:0] sz;
  logic signed [EW-1:0] res;

  assign sum = $signed({2'b00, cur_i}) + $signed({{2{step_i[AW-1]}}, step_i});
  assign sz  = $signed({2'b00, size_i});

  always_comb begin
    if (sum >= sz)       res = sum - sz;
    else if (sum < 0)    res = sum + sz;
    else                 res = sum;
  end

  always_comb begin
    if (!circ_i)                  nxt_o = cur_i + step_i;
    else if (size_i <= AW'(1))    nxt_o = cur_i;
    else                          nxt_o = res[AW-1:0];
  end

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import cag_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NUM_AR = 8,
  localparam int NUM_PTR   = NUM_AR + 1,
  localparam int PIW       = $clog2(NUM_PTR),
  localparam int NUM_START = NUM_AR / 2 + 1,
  localparam int NUM_SIZE  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_kind_i,
  input  logic [PIW-1:0] wr_idx_i,
  input  logic [AW-1:0]  wr_data_i,
  input  logic           req_i,
  input  logic [PIW-1:0] req_ptr_i,
  input  logic [AW-1:0]  req_step_i,
  output logic           vld_o,
  output logic [AW-1:0]  addr_o,
  output logic [AW-1:0]  ptr_o
);

  logic [AW-1:0] ptr_q   [NUM_PTR];
  logic          mode_q  [NUM_PTR];
  logic [AW-1:0] size_q  [NUM_SIZE];
  logic [AW-1:0] start_q [NUM_START];

  logic          req_ok;
  logic [AW-1:0] cur_ptr;
  logic          sel_circ;
  logic [AW-1:0] sel_size;
  logic [AW-1:0] sel_start;
  logic [AW-1:0] nxt_ptr;
  logic [AW-1:0] eff_addr;

  assign req_ok = req_i && (req_ptr_i < PIW'(NUM_PTR));

  cag_regfile #(.AW(AW), .NUM_AR(NUM_AR)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (wr_kind_e'(wr_kind_i)),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (req_ok),
    .upd_idx_i (req_ptr_i),
    .upd_val_i (nxt_ptr),
    .ptr_o     (ptr_q),
    .mode_o    (mode_q),
    .size_o    (size_q),
    .start_o   (start_q)
  );

  cag_select #(.AW(AW), .NUM_AR(NUM_AR)) u_sel (
    .idx_i   (req_ptr_i),
    .ptr_i   (ptr_q),
    .mode_i  (mode_q),
    .size_i  (size_q),
    .start_i (start_q),
    .cur_o   (cur_ptr),
    .circ_o  (sel_circ),
    .size_o  (sel_size),
    .start_o (sel_start)
  );

  cag_step #(.AW(AW)) u_step (
    .cur_i  (cur_ptr),
    .step_i (req_step_i),
    .size_i (sel_size),
    .circ_i (sel_circ),
    .nxt_o  (nxt_ptr)
  );

  // post-modify: address from the pre-update value
  assign eff_addr = sel_circ ? (sel_start + cur_ptr) : cur_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      ptr_o  <= '0;
    end else begin
      vld_o <= req_ok;
      if (req_ok) begin
        addr_o <= eff_addr;
        ptr_o  <= nxt_ptr;
      end
    end
  end

endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int AW  = 16,
  parameter int PIW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic [PIW-1:0] req_ptr_i,
  input logic           req_ok,
  input logic           sel_circ,
  input logic [AW-1:0]  sel_size,
  input logic [AW-1:0]  cur_ptr,
  input logic [AW-1:0]  req_step_i,
  input logic           vld_o,
  input logic [AW-1:0]  addr_o,
  input logic [AW-1:0]  ptr_o
);

  logic [AW-1:0] step_mag;
  assign step_mag = req_step_i[AW-1] ? (~req_step_i + AW'(1)) : req_step_i;

  // R9: valid only after an in-range request
  p_vld_follows_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && req_ptr_i <= PIW'(8)) |=> !vld_o);

  // R2: linear address is the pre-update pointer
  p_lin_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && !sel_circ) |=> (vld_o && addr_o == $past(cur_ptr)));

  // R2: linear update is a plain modular add
  p_lin_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && !sel_circ) |=> (ptr_o == $past(cur_ptr) + $past(req_step_i)));

  // R4 and R5: a legal circular update stays inside the buffer
  p_circ_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && sel_circ && sel_size > AW'(1) && cur_ptr < sel_size && step_mag <= sel_size)
      |=> (ptr_o < $past(sel_size)));

  // R7: degenerate buffer holds the pointer
  p_hold_small_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && sel_circ && sel_size <= AW'(1)) |=> (vld_o && ptr_o == $past(cur_ptr)));

endmodule

bind circ_addr_gen cag_checker #(.AW(AW), .PIW(PIW)) u_cag_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .req_ptr_i  (req_ptr_i),
  .req_ok     (req_ok),
  .sel_circ   (sel_circ),
  .sel_size   (sel_size),
  .cur_ptr    (cur_ptr),
  .req_step_i (req_step_i),
  .vld_o      (vld_o),
  .addr_o     (addr_o),
  .ptr_o      (ptr_o)
);

// File: tb/circ_addr_gen_tb_top.sv
`timescale 1ns/1ps
module circ_addr_gen_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_kind_i = '0;
  logic [3:0]  wr_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        req_i = 1'b0;
  logic [3:0]  req_ptr_i = '0;
  logic [15:0] req_step_i = '0;
  logic        vld_o;
  logic [15:0] addr_o;
  logic [15:0] ptr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  circ_addr_gen dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_kind_i, .wr_idx_i, .wr_data_i,
    .req_i, .req_ptr_i, .req_step_i, .vld_o, .addr_o, .ptr_o
  );

  typedef struct packed {
    logic        acc;
    logic [1:0]  kind;
    logic [3:0]  idx;
    logic [15:0] data;
    logic [15:0] e_addr;
    logic [15:0] e_ptr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 34;
  // kind: 0 ptr, 1 size, 2 start, 3 mode (R10)
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 4'd4, 16'h0001, 16'h0000, 16'h0001, 4'd1},  // R1 reset pointer zero, linear
    '{1'b0, 2'd3, 4'd0, 16'h0001, 16'h0,    16'h0,    4'd10}, // R10 mode AR0 circular
    '{1'b0, 2'd1, 4'd0, 16'd10,   16'h0,    16'h0,    4'd10},
    '{1'b0, 2'd2, 4'd0, 16'h1000, 16'h0,    16'h0,    4'd10},
    '{1'b0, 2'd0, 4'd0, 16'd7,    16'h0,    16'h0,    4'd10},
    '{1'b1, 2'd0, 4'd0, 16'd2,    16'h1007, 16'd9,    4'd3},  // R3
    '{1'b1, 2'd0, 4'd0, 16'd3,    16'h1009, 16'd2,    4'd4},  // R4
    '{1'b1, 2'd0, 4'd0, -16'sd5,  16'h1002, 16'd7,    4'd5},  // R5
    '{1'b1, 2'd0, 4'd0, 16'd0,    16'h1007, 16'd7,    4'd3},
    '{1'b0, 2'd3, 4'd1, 16'h0001, 16'h0,    16'h0,    4'd10},
    '{1'b0, 2'd0, 4'd1, 16'd0,    16'h0,    16'h0,    4'd10},
    '{1'b1, 2'd0, 4'd1, -16'sd1,  16'h1000, 16'd9,    4'd5},  // R5 exact -1
    '{1'b1, 2'd0, 4'd1, 16'd1,    16'h1009, 16'd0,    4'd4},  // R4 exact boundary
    '{1'b0, 2'd1, 4'd1, 16'd4,    16'h0,    16'h0,    4'd6},  // R6 high group
    '{1'b0, 2'd2, 4'd2, 16'h2000, 16'h0,    16'h0,    4'd6},
    '{1'b0, 2'd3, 4'd5, 16'h0001, 16'h0,    16'h0,    4'd6},
    '{1'b0, 2'd0, 4'd5, 16'd3,    16'h0,    16'h0,    4'd6},
    '{1'b1, 2'd0, 4'd5, 16'd4,    16'h2003, 16'd3,    4'd6},  // R6 step = size
    '{1'b1, 2'd0, 4'd5, -16'sd4,  16'h2003, 16'd3,    4'd5},
    '{1'b1, 2'd0, 4'd5, 16'd1,    16'h2003, 16'd0,    4'd4},
    '{1'b0, 2'd1, 4'd2, 16'd5,    16'h0,    16'h0,    4'd6},  // R6 coefficient
    '{1'b0, 2'd2, 4'd4, 16'h3000, 16'h0,    16'h0,    4'd6},
    '{1'b0, 2'd3, 4'd8, 16'h0001, 16'h0,    16'h0,    4'd6},
    '{1'b0, 2'd0, 4'd8, 16'd4,    16'h0,    16'h0,    4'd6},
    '{1'b1, 2'd0, 4'd8, 16'd2,    16'h3004, 16'd1,    4'd6},
    '{1'b0, 2'd0, 4'd3, 16'hFFFF, 16'h0,    16'h0,    4'd2},
    '{1'b1, 2'd0, 4'd3, 16'd2,    16'hFFFF, 16'h0001, 4'd2},  // R2 wrap up
    '{1'b1, 2'd0, 4'd3, -16'sd3,  16'h0001, 16'hFFFE, 4'd2},  // R2 wrap down
    '{1'b0, 2'd2, 4'd1, 16'hFFFE, 16'h0,    16'h0,    4'd3},
    '{1'b0, 2'd3, 4'd2, 16'h0001, 16'h0,    16'h0,    4'd3},
    '{1'b0, 2'd0, 4'd2, 16'd5,    16'h0,    16'h0,    4'd3},
    '{1'b1, 2'd0, 4'd2, 16'd1,    16'h0003, 16'd6,    4'd3},  // R3 address wrap
    '{1'b0, 2'd3, 4'd6, 16'h0001, 16'h0,    16'h0,    4'd7},
    '{1'b0, 2'd2, 4'd3, 16'h4000, 16'h0,    16'h0,    4'd7}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] k, input logic [3:0] i, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_kind_i = k; wr_idx_i = i; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_acc(input logic [3:0] p, input logic [15:0] st,
                        input logic [15:0] ea, input logic [15:0] ep, input int rq);
    string t;
    @(negedge clk_i);
    req_i = 1'b1; req_ptr_i = p; req_step_i = st;
    @(negedge clk_i);
    req_i = 1'b0;
    t = $sformatf("R%0d", rq);
    check({t, " vld"}, {15'd0, vld_o}, 16'd1);
    check({t, " addr"}, addr_o, ea);
    check({t, " ptr"}, ptr_o, ep);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 vld after reset", {15'd0, vld_o}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 vld idle", {15'd0, vld_o}, 16'd0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].acc)
        do_acc(VECS[v].idx, VECS[v].data, VECS[v].e_addr, VECS[v].e_ptr, int'(VECS[v].rq));
      else
        do_write(VECS[v].kind, VECS[v].idx, VECS[v].data);
    end

    // R7: size 1 then size 0 hold the pointer (AR6, group high)
    do_write(2'd1, 4'd1, 16'd1);
    do_write(2'd0, 4'd6, 16'd0);
    do_acc(4'd6, 16'd3, 16'h4000, 16'd0, 7);
    do_write(2'd1, 4'd1, 16'd0);
    do_acc(4'd6, -16'sd2, 16'h4000, 16'd0, 7);

    // R8: write and update of AR3 in one cycle, write wins
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_kind_i = 2'd0; wr_idx_i = 4'd3; wr_data_i = 16'h0050;
    req_i = 1'b1; req_ptr_i = 4'd3; req_step_i = 16'd1;
    @(negedge clk_i);
    wr_en_i = 1'b0; req_i = 1'b0;
    check("R8 addr", addr_o, 16'hFFFE);
    check("R8 ptr_o", ptr_o, 16'hFFFF);
    do_acc(4'd3, 16'd0, 16'h0050, 16'h0050, 8);

    // R9: invalid index and idle cycle produce no result, no change
    @(negedge clk_i);
    req_i = 1'b1; req_ptr_i = 4'd9; req_step_i = 16'd1;
    @(negedge clk_i);
    req_i = 1'b0;
    check("R9 vld invalid index", {15'd0, vld_o}, 16'd0);
    @(negedge clk_i);
    check("R9 vld idle", {15'd0, vld_o}, 16'd0);
    do_acc(4'd3, 16'd0, 16'h0050, 16'h0050, 9);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule